// File: doc/BRIEF.md
# Result Bus Broadcast Arbiter

This block decides which finished function units may put their results on the shared result buses in the current cycle. Every function unit that has completed an instruction raises a completion request. The request carries the instruction tag, the destination register, a flag that says whether a destination exists, and a stamp of the cycle in which execution finished. The arbiter grants up to `NUM_BUSES` of these requests each cycle. It drives the granted tags and destinations onto the buses for that cycle only, and it raises `cmp_ready` toward each granted unit. That ready pulse is the unit's signal that it is free.

Each completion port is a valid/ready channel. A unit raises `cmp_valid` with its payload and must hold the valid bit and every payload field unchanged until it sees `cmp_ready` high at a clock edge. While it waits, the unit stays busy and accepts no new work, so bus contention pushes back into issue. The block contains no state. Grants and bus contents are a pure function of the requests present in the cycle, so nothing carries over between cycles. Cycle stamps are compared modulo 2^`CYC_W`, which stays correct as long as no pending request is older than half that range.

Top module: `rb_arbiter`

## Requirements
- R1: The number of `cmp_ready` bits that are high equals the smaller of `NUM_BUSES` and the number of `cmp_valid` bits that are high.
- R2: `cmp_ready` is never high without `cmp_valid`. A valid request that loses arbitration sees `cmp_ready` low and appears on no bus in that cycle.
- R3: Every granted unit's tag, destination and write flag appear on exactly one bus in the same cycle as its `cmp_ready`. No bus is fed by two units.
- R4: The bus outputs follow the present requests with no latching. With no request valid, every `bus_valid` bit is 0.
- R5: A request with an older cycle stamp beats a request with a younger one. Stamp a is older than b when bit `CYC_W-1` of (a - b mod 2^`CYC_W`) is 1, so 16'hFFFE is older than 16'h0001.
- R6: Among requests with equal cycle stamps, the lower tag value wins. If both stamp and tag are equal, the lower unit index wins.
- R7: Grants are packed onto buses in priority order. Bus 0 carries the highest-priority grant, bus 1 the next, and so on. A bus with no grant drives `bus_valid` 0, and bus k is valid only if bus k-1 is valid.
- R8: A request with `cmp_dst_en` at 0 is arbitrated and broadcast like any other. Its bus drives `bus_wr` 0. `bus_wr` is never 1 on an invalid bus.
- R9: The parameters must satisfy 1 <= `NUM_BUSES` <= `NUM_UNITS` and `CYC_W` <= 32. Any other setting stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cmp_valid | input | NUM_UNITS | Completion request per function unit |
| cmp_ready | output | NUM_UNITS | Grant; the unit is freed in this cycle |
| cmp_tag | input | NUM_UNITS*TAG_W | Tag of each unit's finished instruction |
| cmp_dst | input | NUM_UNITS*REG_W | Destination register per unit |
| cmp_dst_en | input | NUM_UNITS | 1 when the instruction writes a register |
| cmp_cycle | input | NUM_UNITS*CYC_W | Cycle stamp of each completion |
| bus_valid | output | NUM_BUSES | Bus carries a broadcast this cycle |
| bus_tag | output | NUM_BUSES*TAG_W | Broadcast tag per bus |
| bus_dst | output | NUM_BUSES*REG_W | Broadcast destination per bus |
| bus_wr | output | NUM_BUSES | Broadcast writes a register |

## Verification
The hardest state to reach from the ports is a backlog. In that state several units have been waiting across many cycles behind one another, alongside fresh completions with lower tags. At the same moment the cycle stamps wrap through zero, so a numerically larger stamp is in fact the older one. The bench models a set of units that keep holding their results until granted. It raises new completions at a rate above what two buses can drain and starts the cycle stamp just below the wrap point. On top of that come directed cases for stamp order, tag order, the wrap and a request with no destination.

// File: rtl/rba_pkg.sv
package rba_pkg;

  // Modular age test: a is older than b when (a - b) is negative in w bits.
  function automatic logic stamp_older(input logic [31:0] a, input logic [31:0] b, input int w);
    logic [31:0] diff;
    diff = a - b;
    return diff[w-1];
  endfunction

endpackage

// File: rtl/rba_prio_matrix.sv
module rba_prio_matrix #(
  parameter int N     = 6,
  parameter int TAG_W = 8,
  parameter int CYC_W = 16
) (
  input  logic [N-1:0]       req,
  input  logic [N*TAG_W-1:0] tags,
  input  logic [N*CYC_W-1:0] stamps,
  output logic [N*N-1:0]     beats   // beats[i*N+j]: request i outranks request j
);
  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      if (gi == gj) begin : g_self
        assign beats[gi*N+gj] = 1'b0;
      end else begin : g_pair
        logic [TAG_W-1:0] ti, tj;
        logic i_old, j_old, win;
        assign ti    = tags[gi*TAG_W +: TAG_W];
        assign tj    = tags[gj*TAG_W +: TAG_W];
        assign i_old = rba_pkg::stamp_older(32'(stamps[gi*CYC_W +: CYC_W]),
                                            32'(stamps[gj*CYC_W +: CYC_W]), CYC_W);
        assign j_old = rba_pkg::stamp_older(32'(stamps[gj*CYC_W +: CYC_W]),
                                            32'(stamps[gi*CYC_W +: CYC_W]), CYC_W);
        always_comb begin
          if (i_old)         win = 1'b1;
          else if (j_old)    win = 1'b0;
          else if (ti != tj) win = (ti < tj);
          else               win = (gi < gj);
        end
        assign beats[gi*N+gj] = req[gi] & req[gj] & win;
      end
    end
  end
endmodule

// File: rtl/rba_rank.sv
module rba_rank #(
  parameter int N  = 6,
  parameter int R  = 2,
  localparam int RW = $clog2(N + 1)
) (
  input  logic [N-1:0]    req,
  input  logic [N*N-1:0]  beats,
  output logic [N*RW-1:0] rank,
  output logic [N-1:0]    grant
);
  for (genvar gi = 0; gi < N; gi++) begin : g_unit
    logic [RW-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int j = 0; j < N; j++) cnt = cnt + RW'(beats[j*N+gi]);
    end
    assign rank[gi*RW +: RW] = cnt;
    assign grant[gi]         = req[gi] && (cnt < RW'(R));
  end

  always_comb begin
    a_r1_bus_limit: assert ($countones(grant) <= R);
    a_r1_fill: assert ($countones(grant) ==
                       (($countones(req) < R) ? $countones(req) : R));
  end
endmodule

// File: rtl/rba_bus_drive.sv
module rba_bus_drive #(
  parameter int N     = 6,
  parameter int R     = 2,
  parameter int TAG_W = 8,
  parameter int REG_W = 7,
  localparam int RW   = $clog2(N + 1)
) (
  input  logic [N-1:0]       grant,
  input  logic [N*RW-1:0]    rank,
  input  logic [N*TAG_W-1:0] tags,
  input  logic [N*REG_W-1:0] dsts,
  input  logic [N-1:0]       dst_en,
  output logic [R-1:0]       bus_valid,
  output logic [R*TAG_W-1:0] bus_tag,
  output logic [R*REG_W-1:0] bus_dst,
  output logic [R-1:0]       bus_wr
);
  for (genvar gk = 0; gk < R; gk++) begin : g_bus
    logic [N-1:0]     sel;
    logic [TAG_W-1:0] t;
    logic [REG_W-1:0] d;
    logic             w;
    always_comb begin
      for (int i = 0; i < N; i++) sel[i] = grant[i] && (rank[i*RW +: RW] == RW'(gk));
    end
    always_comb begin
      t = '0;
      d = '0;
      w = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (sel[i]) begin
          t = t | tags[i*TAG_W +: TAG_W];
          d = d | dsts[i*REG_W +: REG_W];
          w = w | dst_en[i];
        end
      end
    end
    assign bus_valid[gk]               = |sel;
    assign bus_tag[gk*TAG_W +: TAG_W]  = t;
    assign bus_dst[gk*REG_W +: REG_W]  = d;
    assign bus_wr[gk]                  = w;

    always_comb begin
      a_r3_single_source: assert ($onehot0(sel));
    end
    if (gk > 0) begin : g_pack
      always_comb begin
        a_r7_packed: assert (!bus_valid[gk] || bus_valid[gk-1]);
      end
    end
  end
endmodule

// File: rtl/rb_arbiter.sv
module rb_arbiter #(
  parameter int NUM_UNITS = 6,
  parameter int NUM_BUSES = 2,
  parameter int TAG_W     = 8,
  parameter int REG_W     = 7,
  parameter int CYC_W     = 16
) (
  input  logic [NUM_UNITS-1:0]       cmp_valid,
  output logic [NUM_UNITS-1:0]       cmp_ready,
  input  logic [NUM_UNITS*TAG_W-1:0] cmp_tag,
  input  logic [NUM_UNITS*REG_W-1:0] cmp_dst,
  input  logic [NUM_UNITS-1:0]       cmp_dst_en,
  input  logic [NUM_UNITS*CYC_W-1:0] cmp_cycle,
  output logic [NUM_BUSES-1:0]       bus_valid,
  output logic [NUM_BUSES*TAG_W-1:0] bus_tag,
  output logic [NUM_BUSES*REG_W-1:0] bus_dst,
  output logic [NUM_BUSES-1:0]       bus_wr
);
  localparam int RW = $clog2(NUM_UNITS + 1);

  // R9: reject illegal sizing at elaboration
  if (NUM_BUSES < 1 || NUM_BUSES > NUM_UNITS || CYC_W > 32) begin : g_bad_params
    $error("rb_arbiter: illegal parameters (R9)");
  end

  logic [NUM_UNITS*NUM_UNITS-1:0] beats;
  logic [NUM_UNITS*RW-1:0]        rank;
  logic [NUM_UNITS-1:0]           grant;

  rba_prio_matrix #(.N(NUM_UNITS), .TAG_W(TAG_W), .CYC_W(CYC_W)) u_matrix (
    .req(cmp_valid), .tags(cmp_tag), .stamps(cmp_cycle), .beats(beats)
  );

  rba_rank #(.N(NUM_UNITS), .R(NUM_BUSES)) u_rank (
    .req(cmp_valid), .beats(beats), .rank(rank), .grant(grant)
  );

  rba_bus_drive #(.N(NUM_UNITS), .R(NUM_BUSES), .TAG_W(TAG_W), .REG_W(REG_W)) u_drive (
    .grant(grant), .rank(rank), .tags(cmp_tag), .dsts(cmp_dst), .dst_en(cmp_dst_en),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_dst(bus_dst), .bus_wr(bus_wr)
  );

  assign cmp_ready = grant;

  always_comb begin
    a_r2_ready_needs_valid: assert ((cmp_ready & ~cmp_valid) == '0);
    a_r8_wr_only_on_valid: assert ((bus_wr & ~bus_valid) == '0);
    a_r4_idle_buses: assert ((cmp_valid != '0) || (bus_valid == '0));
  end
endmodule

// File: tb/test_rb_arbiter.sv
`timescale 1ns/1ps
module test_rb_arbiter;
  localparam int N = 6, R = 2, TW = 8, RGW = 7, CW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]      cmp_valid, cmp_ready, cmp_dst_en;
  logic [N*TW-1:0]   cmp_tag;
  logic [N*RGW-1:0]  cmp_dst;
  logic [N*CW-1:0]   cmp_cycle;
  logic [R-1:0]      bus_valid, bus_wr;
  logic [R*TW-1:0]   bus_tag;
  logic [R*RGW-1:0]  bus_dst;

  rb_arbiter #(.NUM_UNITS(N), .NUM_BUSES(R), .TAG_W(TW), .REG_W(RGW), .CYC_W(CW)) i_rb_arbiter (
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_tag(cmp_tag), .cmp_dst(cmp_dst),
    .cmp_dst_en(cmp_dst_en), .cmp_cycle(cmp_cycle), .bus_valid(bus_valid),
    .bus_tag(bus_tag), .bus_dst(bus_dst), .bus_wr(bus_wr)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // Model of the function units holding results
  bit            p_v[N];
  logic [TW-1:0] p_tag[N];
  logic [RGW-1:0] p_dst[N];
  bit            p_den[N];
  logic [CW-1:0] p_cyc[N];
  bit            exp_rdy[N];

  function automatic bit older(logic [CW-1:0] a, logic [CW-1:0] b);
    logic [CW-1:0] d;
    d = a - b;
    return d[CW-1];
  endfunction

  function automatic bit outranks(int i, int j);
    if (older(p_cyc[i], p_cyc[j])) return 1'b1;
    if (older(p_cyc[j], p_cyc[i])) return 1'b0;
    if (p_tag[i] != p_tag[j]) return p_tag[i] < p_tag[j];
    return i < j;
  endfunction

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      cmp_valid[i]             = p_v[i];
      cmp_tag[i*TW +: TW]      = p_tag[i];
      cmp_dst[i*RGW +: RGW]    = p_dst[i];
      cmp_dst_en[i]            = p_den[i];
      cmp_cycle[i*CW +: CW]    = p_cyc[i];
    end
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Compare every output against the model for the present requests.
  task automatic check_all(string label);
    logic [N-1:0] er;
    logic [R-1:0] ev;
    int rk;
    er = '0;
    ev = '0;
    for (int i = 0; i < N; i++) begin
      exp_rdy[i] = 1'b0;
      if (p_v[i]) begin
        rk = 0;
        for (int j = 0; j < N; j++) if (j != i && p_v[j] && outranks(j, i)) rk++;
        if (rk < R) begin
          exp_rdy[i] = 1'b1;
          er[i] = 1'b1;
          ev[rk] = 1'b1;
          check(bus_tag[rk*TW +: TW] == p_tag[i], "R3/R5/R6", {label, " bus tag"},
                bus_tag[rk*TW +: TW], p_tag[i]);
          check(bus_dst[rk*RGW +: RGW] == p_dst[i], "R3/R7", {label, " bus dst"},
                bus_dst[rk*RGW +: RGW], p_dst[i]);
          check(bus_wr[rk] == p_den[i], "R8", {label, " bus wr"}, bus_wr[rk], p_den[i]);
        end
      end
    end
    check(cmp_ready == er, "R1/R2", {label, " ready"}, cmp_ready, er);
    check(bus_valid == ev, "R4/R7", {label, " bus valid"}, bus_valid, ev);
    check((bus_wr & ~bus_valid) == '0, "R8", {label, " wr on idle bus"}, bus_wr, bus_wr & bus_valid);
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      p_v[i] = 0; p_tag[i] = '0; p_dst[i] = '0; p_den[i] = 0; p_cyc[i] = '0;
    end
  endtask

  task automatic set_u(int i, logic [CW-1:0] c, logic [TW-1:0] t, logic [RGW-1:0] d, bit de);
    p_v[i] = 1; p_cyc[i] = c; p_tag[i] = t; p_dst[i] = d; p_den[i] = de;
  endtask

  task automatic step(string label);
    @(negedge clk);
    drive();
    #2;
    check_all(label);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] now;
    logic [TW-1:0] next_tag;
    int seed, off;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    clear_all();
    drive();

    // R4: nothing pending, all buses idle
    step("R4 empty");
    check(bus_valid == '0 && cmp_ready == '0, "R4", "idle outputs", {bus_valid, cmp_ready}, 0);

    // R5: older stamp beats lower tag
    clear_all();
    set_u(0, 16'd10, 8'd1, 7'd3, 1);
    set_u(1, 16'd9, 8'd200, 7'd4, 1);
    set_u(2, 16'd11, 8'd0, 7'd5, 1);
    step("R5 age order");
    check(bus_tag[7:0] == 8'd200 && cmp_ready[2] == 1'b0, "R5", "oldest first", bus_tag[7:0], 200);

    // R5: stamp wrap, FFFE is oldest, then 0001, then 0002
    clear_all();
    set_u(3, 16'hFFFE, 8'd9, 7'd1, 1);
    set_u(4, 16'h0002, 8'd1, 7'd2, 1);
    set_u(5, 16'h0001, 8'd0, 7'd3, 1);
    step("R5 wrap");
    check(bus_tag == {8'd0, 8'd9} && cmp_ready == 6'b101000, "R5", "wrap order",
          {bus_tag, cmp_ready}, {8'd0, 8'd9, 6'b101000});

    // R6: same stamp, lower tag wins; R2: losers stay ready low
    clear_all();
    set_u(0, 16'd7, 8'd40, 7'd1, 1);
    set_u(1, 16'd7, 8'd12, 7'd2, 1);
    set_u(2, 16'd7, 8'd33, 7'd3, 1);
    set_u(3, 16'd7, 8'd5, 7'd4, 1);
    set_u(4, 16'd7, 8'd20, 7'd5, 1);
    step("R6 tag order");
    check(bus_tag == {8'd12, 8'd5} && cmp_ready == 6'b001010, "R6", "lowest tags",
          {bus_tag, cmp_ready}, {8'd12, 8'd5, 6'b001010});
    // R2: granted units leave, waiting ones hold and win next
    p_v[1] = 0; p_v[3] = 0;
    step("R2 held retry");
    check(bus_tag == {8'd33, 8'd20}, "R2", "held requests granted next", bus_tag, {8'd33, 8'd20});

    // R8: no destination still broadcast, write flag low; R7: bus 1 idle
    clear_all();
    set_u(2, 16'd50, 8'd77, 7'd0, 0);
    step("R8 no dest");
    check(bus_valid == 2'b01 && bus_wr == 2'b00 && bus_tag[7:0] == 8'd77, "R8", "broadcast without write",
          {bus_valid, bus_wr}, 4'b0100);

    // R6: equal stamp and tag, lower unit index wins
    clear_all();
    set_u(4, 16'd3, 8'd8, 7'd9, 1);
    set_u(1, 16'd3, 8'd8, 7'd6, 1);
    set_u(5, 16'd3, 8'd8, 7'd2, 1);
    step("R6 index tie");
    check(bus_dst == {7'd9, 7'd6}, "R6", "index tie-break", bus_dst, {7'd9, 7'd6});

    // Random backlog with stamps wrapping through zero
    clear_all();
    now = 16'hFFC0;
    next_tag = '0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      off = $urandom_range(N - 1);
      for (int k = 0; k < N; k++) begin
        int u;
        u = (k + off) % N;
        if (!p_v[u] && ($urandom_range(99) < 45)) begin
          set_u(u, now, next_tag, 7'($urandom_range(127)), ($urandom_range(7) != 0));
          next_tag++;
        end
      end
      step("R1-random");
      for (int i = 0; i < N; i++) if (exp_rdy[i]) p_v[i] = 0;
      now++;
    end

    clear_all();
    step("R4 drained");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule